// File: doc/BRIEF.md
# Per-Priority Interrupt Backlog Counter Bank

This block keeps a count of backlogged interrupts for each of eight priority levels. It holds two sets of counters. The individual-target set records only whether something is waiting, so each of its counters is 0 or 1. The group set records how many interrupts are waiting, and each of its counters is a saturating value.

Software reaches the counters through a pair of adjacent memory-mapped pages. The individual page comes first and the group page second. Within a page, the access address encodes both the operation and the priority. A store changes a counter by the byte that was written. An increment or decrement load is an atomic fetch-and-modify: it returns the old count and then moves the counter by one. A plain-read load returns the count and leaves it as it is.

A separate event port lets the interrupt routing logic bump a counter when it backlogs an interrupt. An event always wins over bus traffic in the same cycle.

Top module: `backlog_bank`

## Requirements
- R1: After reset, every counter in both sets reads 0 and `rsp_valid` is low.
- R2: Address bit 12 selects the page (0 individual, 1 group). Bits [11:10] select the operation (00 increment, 01 decrement, 1x plain read). Bits [6:4] select the priority. No other address bit has an effect, and each priority has its own counter.
- R3: An increment store to a group counter adds the written byte. The result saturates at the counter's maximum, 2^GRP_W-1.
- R4: A decrement store to a group counter subtracts the written byte. The result saturates at 0.
- R5: An increment or decrement load returns the pre-access count, zero-extended on `rsp_data`, one cycle after acceptance. The counter then changes by exactly one.
- R6: A decrement load on a zero counter leaves it at 0. An increment load on a full group counter leaves it at the maximum.
- R7: An individual counter holds only 0 or 1. Any increment, store or load, sets it to 1. A decrement load, or a decrement store with a nonzero byte, clears it. A decrement store of 0 leaves it unchanged.
- R8: A plain-read load returns the count without changing it. A store that uses a plain-read code changes nothing.
- R9: While `evt_valid` is high, `req_ready` is low and the event is applied. The event sets an individual counter to 1, or adds one to a group counter with saturation. A bus request held through that cycle is accepted on the next cycle without an event.
- R10: `rsp_valid` pulses for one cycle after each accepted load and never after a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access request |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | PAGE_BIT+1 (13) | Page offset encoding page, operation and priority |
| req_wdata | input | DELTA_W (8) | Store delta |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | RSP_W (16) | Count before the access |
| evt_valid | input | 1 | Routing-logic backlog event |
| evt_group | input | 1 | Event targets group set when high |
| evt_prio | input | 3 | Event priority |

## Verification
The bench builds the block with GRP_W set to 6, so group counters top out at 63. That value is reachable with a single byte store, so the increment saturation paths of R3 and R6 can be reached directly. All other parameters keep their defaults: eight priorities, an 8-bit delta and a 16-bit result. With those defaults the full address decode is exercised, and a store delta wider than the counter checks that the saturating adder handles mismatched widths.

// File: rtl/backlog_bank.sv
module backlog_bank #(
  parameter int NUM_PRIO = 8,
  parameter int GRP_W    = 16,
  parameter int DELTA_W  = 8,
  parameter int RSP_W    = 16,
  parameter int PRIO_LSB = 4,
  parameter int OP_LSB   = 10,
  parameter int PAGE_BIT = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [PAGE_BIT:0]           req_addr,
  input  logic [DELTA_W-1:0]          req_wdata,
  output logic                        rsp_valid,
  output logic [RSP_W-1:0]            rsp_data,
  input  logic                        evt_valid,
  input  logic                        evt_group,
  input  logic [$clog2(NUM_PRIO)-1:0] evt_prio
);
  localparam int PRIO_W = $clog2(NUM_PRIO);
  localparam int SUM_W  = ((GRP_W > DELTA_W) ? GRP_W : DELTA_W) + 1;
  localparam logic [SUM_W-1:0] GRP_MAX = SUM_W'({GRP_W{1'b1}});

  logic [NUM_PRIO-1:0] ind_cnt;
  logic [GRP_W-1:0]    grp_cnt [NUM_PRIO];

  wire              acc    = req_valid & req_ready;
  wire [1:0]        op     = req_addr[OP_LSB +: 2];
  wire [PRIO_W-1:0] prio   = req_addr[PRIO_LSB +: PRIO_W];
  wire              grp    = req_addr[PAGE_BIT];
  wire              is_rd  = op[1];
  wire              is_dec = op[0];
  wire              is_ld  = acc & ~req_write;

  assign req_ready = ~evt_valid;

  wire [SUM_W-1:0] amt    = req_write ? SUM_W'(req_wdata) : SUM_W'(1);
  wire [SUM_W-1:0] cur    = SUM_W'(grp_cnt[prio]);
  wire [SUM_W-1:0] up     = cur + amt;
  wire [GRP_W-1:0] grp_up = (up > GRP_MAX) ? GRP_MAX[GRP_W-1:0] : up[GRP_W-1:0];
  wire [SUM_W-1:0] dn     = cur - amt;
  wire [GRP_W-1:0] grp_dn = (amt >= cur) ? '0 : dn[GRP_W-1:0];
  wire             ind_nx = is_dec ? ((amt == '0) ? ind_cnt[prio] : 1'b0) : 1'b1;

  wire [GRP_W-1:0] evt_cur = grp_cnt[evt_prio];
  wire [GRP_W-1:0] evt_up  = (&evt_cur) ? evt_cur : evt_cur + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_cnt   <= '0;
      grp_cnt   <= '{default: '0};
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= is_ld;
      if (is_ld)
        rsp_data <= grp ? RSP_W'(grp_cnt[prio]) : RSP_W'(ind_cnt[prio]);
      if (evt_valid) begin
        if (evt_group) grp_cnt[evt_prio] <= evt_up;
        else           ind_cnt[evt_prio] <= 1'b1;
      end else if (acc && !is_rd) begin
        if (grp) grp_cnt[prio] <= is_dec ? grp_dn : grp_up;
        else     ind_cnt[prio] <= ind_nx;
      end
    end
  end

  AST_RSP_ONLY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !evt_valid && !req_write)); // R10
  AST_GRP_INC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && grp && !is_rd && !is_dec && cur == GRP_MAX) |=> grp_cnt[$past(prio)] == GRP_MAX[GRP_W-1:0]); // R3
  AST_GRP_DEC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && grp && !is_rd && is_dec && cur == '0) |=> grp_cnt[$past(prio)] == '0); // R4
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && grp && is_rd) |=> grp_cnt[$past(prio)] == $past(grp_cnt[prio])); // R8
  AST_IND_DEC_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ld && !grp && !is_rd && is_dec) |=> !ind_cnt[$past(prio)]); // R7
  AST_EVT_SETS_IND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_group) |=> ind_cnt[$past(evt_prio)]); // R9
endmodule

// File: tb/sim_backlog_bank.sv
module sim_backlog_bank;
  localparam int GW  = 6;
  localparam int MAX = (1 << GW) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, evt_valid = 0, evt_group = 0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [2:0]  evt_prio = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;

  backlog_bank #(.GRP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .evt_valid(evt_valid),
    .evt_group(evt_group), .evt_prio(evt_prio));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int m_ind[8], m_grp[8];
  bit finished = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, bit g, int op, int p, int d,
                      bit ev, bit eg, int ep, string tag);
    bit exp_rv;
    int exp_rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_wdata = 8'(d);
    req_addr = {g, 2'(op), 3'($urandom), 3'(p), 4'($urandom)};
    evt_valid = ev; evt_group = eg; evt_prio = 3'(ep);
    #1 check({tag, " ready"}, int'(req_ready), int'(!ev));
    exp_rv = 0; exp_rd = 0;
    if (ev) begin
      if (eg) m_grp[ep] = (m_grp[ep] == MAX) ? MAX : m_grp[ep] + 1;
      else    m_ind[ep] = 1;
    end else if (v) begin
      int cur, amt;
      cur = g ? m_grp[p] : m_ind[p];
      amt = w ? d : 1;
      if (!w) begin exp_rv = 1; exp_rd = cur; end
      if (op < 2) begin
        if (g) m_grp[p] = (op == 1) ? ((amt >= cur) ? 0 : cur - amt)
                                    : ((cur + amt > MAX) ? MAX : cur + amt);
        else   m_ind[p] = (op == 1) ? ((amt == 0) ? cur : 0) : 1;
      end
    end
    @(posedge clk); #1;
    check({tag, " rsp_valid"}, int'(rsp_valid), int'(exp_rv));
    if (exp_rv) check({tag, " rsp_data"}, int'(rsp_data), exp_rd);
  endtask

  task automatic st(bit g, int op, int p, int d, string tag);
    step(1, 1, g, op, p, d, 0, 0, 0, tag);
  endtask
  task automatic ld(bit g, int op, int p, string tag);
    step(1, 0, g, op, p, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_ind[i]) begin m_ind[i] = 0; m_grp[i] = 0; end
    #20;
    check("R1 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    for (int p = 0; p < 8; p++) begin
      ld(0, 2, p, "R1 ind zero");
      ld(1, 3, p, "R1 grp zero");
    end
    // R3 R5 group fetch-and-modify
    st(1, 0, 2, 9, "R3 inc store");
    ld(1, 0, 2, "R5 inc load");
    ld(1, 1, 2, "R5 dec load");
    ld(1, 2, 2, "R8 read x");
    ld(1, 3, 2, "R8 read y");
    // R4 R6 saturation at zero
    st(1, 1, 2, 200, "R4 dec store");
    ld(1, 1, 2, "R6 dec load at zero");
    ld(1, 2, 2, "R6 still zero");
    // R3 R6 saturation at max
    st(1, 0, 4, 250, "R3 inc store sat");
    ld(1, 0, 4, "R6 inc load at max");
    ld(1, 2, 4, "R6 still max");
    // R7 individual
    st(0, 0, 2, 7, "R7 ind inc store");
    ld(0, 0, 2, "R7 ind inc load");
    ld(0, 2, 2, "R7 ind stays one");
    st(0, 1, 2, 0, "R7 ind dec zero delta");
    ld(0, 1, 2, "R7 ind dec load");
    st(0, 1, 2, 3, "R7 ind dec at zero");
    ld(0, 3, 2, "R7 ind zero");
    // R8 store to read code ignored
    st(1, 2, 3, 5, "R8 store read code");
    st(0, 3, 3, 5, "R8 store read code ind");
    ld(1, 2, 3, "R8 grp unchanged");
    ld(0, 2, 3, "R8 ind unchanged");
    // R2 per-priority isolation
    for (int p = 0; p < 8; p++) st(1, 0, p, p + 1, "R2 fill");
    for (int p = 0; p < 8; p++) ld(1, 2, p, "R2 isolated");
    // R9 event priority over bus
    step(1, 0, 1, 0, 5, 0, 1, 1, 5, "R9 evt with bus");
    step(1, 0, 1, 0, 5, 0, 0, 0, 0, "R9 bus next cycle");
    step(0, 0, 0, 0, 0, 0, 1, 0, 6, "R9 evt ind");
    ld(0, 2, 6, "R9 ind set");
    step(0, 0, 0, 0, 0, 0, 1, 1, 4, "R9 evt grp at max");
    ld(1, 2, 4, "R9 grp sat");
    // R10 random mix
    for (int i = 0; i < 600; i++)
      step($urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 4,
           $urandom % 8, ($urandom % 3 == 0) ? $urandom % 256 : $urandom % 4,
           $urandom % 6 == 0, $urandom % 2, $urandom % 8, "R10 random");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule